// File: doc/BRIEF.md
# Partition-Enforcing LRU Victim Selector

This block picks the way to replace on a miss in a set-associative cache shared by two processes, called A and B. It keeps a running count of how many blocks each process holds in the whole cache. It compares each count with a target that configuration supplies for that process. The LRU ranks and owner tags of the addressed set are also inputs. When one process holds more than its target, the victim is taken from that process's oldest block in the set. Otherwise ordinary LRU replacement applies.

The victim way is a combinational function of the set state, the counts and the targets. When a miss request is asserted, the fill happens on that clock edge. On that same edge, the requester's count goes up by one. If the chosen way held a valid block, its previous owner's count goes down by one. Tag lookup, data movement and rank maintenance belong to the surrounding cache.

Top module: `part_lru_victim`

## Requirements
- R1: After synchronous reset both ownership counts (`held_a`, `held_b`) read zero.
- R2: If any way of the set is invalid (`set_valid[i]` = 0), the victim is the invalid way with the lowest index, whatever the owners, counts and targets.
- R3: With all ways valid, when A is over its target (`held_a` > `quota_a`, strictly) and B is not, and A owns at least one way (`set_owner[i]` = 0 means A), the victim is A's way with the largest rank.
- R4: With all ways valid, when B is over its target and A is not, and B owns at least one way (`set_owner[i]` = 1 means B), the victim is B's way with the largest rank.
- R5: A count equal to its target is not over target: the choice falls back to plain LRU.
- R6: With all ways valid and neither process over target, the victim is the way with the largest rank. Way i's rank is `set_rank[i*RANK_W +: RANK_W]`, where 0 is most recent and WAYS-1 is least recent.
- R7: If the over-target process owns no way in the set, plain LRU selects the victim.
- R8: If both processes are over target and both own ways in the set, the process with the larger excess (count minus target) gives up its largest-rank way. Equal excess goes to A.
- R9: When `miss_valid` is high, at the next edge the count of `miss_pid` (0 = A, 1 = B) rises by one. If the victim way was valid, its owner's count falls by one, so the two cancel when they are the same process. With `miss_valid` low, the counts hold.
- R10: Counts saturate: they never exceed 2^CNT_W-1 and never drop below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss with fill this cycle |
| miss_pid | input | 1 | Requesting process (0 = A, 1 = B) |
| set_valid | input | WAYS | Per-way valid bits of the addressed set |
| set_owner | input | WAYS | Per-way owner bit (0 = A, 1 = B) |
| set_rank | input | WAYS*RANK_W | Per-way LRU rank, way i at bits i*RANK_W |
| quota_a | input | CNT_W | Target block count for A |
| quota_b | input | CNT_W | Target block count for B |
| victim_way | output | IDX_W | Chosen way index |
| held_a | output | CNT_W | Blocks currently owned by A |
| held_b | output | CNT_W | Blocks currently owned by B |

## Verification
The bench arranges set layouts in which the oldest block of the over-target process and the oldest block overall sit in different ways. Each result therefore shows which rule picked the victim. Cases with an invalid way present separate the free-way priority from the ownership rules. Cases at exactly the target, and cases where the over-target process owns nothing in the set, separate the plain-LRU fallback from the override. With both processes over target, unequal and then equal excesses show the tie-break. Sequences of fills show the count updates on invalid victims, on victims owned by the other process and on victims owned by the requester, and they drive both counts into saturation at each end.

// File: rtl/plru_pkg.sv
package plru_pkg;

    localparam int NPROC = 2;

    typedef enum logic {
        PID_A = 1'b0,
        PID_B = 1'b1
    } pid_e;

    typedef enum logic [1:0] {
        PICK_FREE,
        PICK_SHED_A,
        PICK_SHED_B,
        PICK_LRU
    } pick_e;

    typedef struct packed {
        logic any_free;
        logic over_a;
        logic over_b;
        logic owns_a;
        logic owns_b;
        logic b_ahead;
    } policy_in_t;

    // Ordered decision: free way, then ownership override, then plain LRU.
    function automatic pick_e decide(input policy_in_t p);
        logic cand_a;
        logic cand_b;
        cand_a = p.over_a && p.owns_a;
        cand_b = p.over_b && p.owns_b;
        if (p.any_free)
            return PICK_FREE;
        if (cand_a && cand_b)
            return p.b_ahead ? PICK_SHED_B : PICK_SHED_A;
        if (cand_a)
            return PICK_SHED_A;
        if (cand_b)
            return PICK_SHED_B;
        return PICK_LRU;
    endfunction

endpackage

// File: rtl/plru_first_set.sv
module plru_first_set #(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic             hit_c [WAYS+1];
    logic [IDX_W-1:0] idx_c [WAYS+1];

    assign hit_c[WAYS] = 1'b0;
    assign idx_c[WAYS] = '0;

    // Chain from the top index down so the lowest set bit wins.
    for (genvar i = 0; i < WAYS; i++) begin : g_stage
        assign hit_c[i] = mask[i] | hit_c[i+1];
        assign idx_c[i] = mask[i] ? IDX_W'(i) : idx_c[i+1];
    end

    assign found = hit_c[0];
    assign idx   = idx_c[0];
endmodule

// File: rtl/plru_oldest.sv
module plru_oldest #(
    parameter int WAYS   = 8,
    parameter int RANK_W = $clog2(WAYS),
    parameter int IDX_W  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]        mask,
    input  logic [WAYS*RANK_W-1:0] rank,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);
    logic              hit_c [WAYS+1];
    logic [IDX_W-1:0]  idx_c [WAYS+1];
    logic [RANK_W-1:0] rk_c  [WAYS+1];

    assign hit_c[0] = 1'b0;
    assign idx_c[0] = '0;
    assign rk_c[0]  = '0;

    // Running maximum over masked ways; strict compare keeps lower index on ties.
    for (genvar i = 0; i < WAYS; i++) begin : g_stage
        logic [RANK_W-1:0] my_rank;
        logic              take;
        assign my_rank    = rank[i*RANK_W +: RANK_W];
        assign take       = mask[i] && (!hit_c[i] || (my_rank > rk_c[i]));
        assign hit_c[i+1] = hit_c[i] | mask[i];
        assign idx_c[i+1] = take ? IDX_W'(i) : idx_c[i];
        assign rk_c[i+1]  = take ? my_rank : rk_c[i];
    end

    assign found = hit_c[WAYS];
    assign idx   = idx_c[WAYS];
endmodule

// File: rtl/plru_occupancy.sv
module plru_occupancy
    import plru_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fill,
    input  logic                        fill_pid,
    input  logic                        drop,
    input  logic                        drop_pid,
    output logic [NPROC-1:0][CNT_W-1:0] held
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        logic up;
        logic dn;
        assign up = fill && (fill_pid == 1'(p));
        assign dn = drop && (drop_pid == 1'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                held[p] <= '0;
            end else if (up && !dn) begin
                if (held[p] != CNT_MAX)
                    held[p] <= held[p] + CNT_W'(1);
            end else if (dn && !up) begin
                if (held[p] != '0)
                    held[p] <= held[p] - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
    import plru_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int CNT_W  = 10,
    parameter int RANK_W = $clog2(WAYS),
    parameter int IDX_W  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]        set_valid,
    input  logic [WAYS-1:0]        set_owner,
    input  logic [WAYS*RANK_W-1:0] set_rank,
    input  logic [CNT_W-1:0]       held_a,
    input  logic [CNT_W-1:0]       held_b,
    input  logic [CNT_W-1:0]       quota_a,
    input  logic [CNT_W-1:0]       quota_b,
    output logic [IDX_W-1:0]       victim
);
    logic [WAYS-1:0]  mask_a;
    logic [WAYS-1:0]  mask_b;
    logic             free_hit, a_hit, b_hit, all_hit;
    logic [IDX_W-1:0] free_idx, a_idx, b_idx, all_idx;
    logic [CNT_W:0]   excess_a;
    logic [CNT_W:0]   excess_b;
    policy_in_t       pol;
    pick_e            pick;

    assign mask_a = set_valid & ~set_owner;
    assign mask_b = set_valid & set_owner;

    plru_first_set #(.WAYS(WAYS), .IDX_W(IDX_W)) u_free (
        .mask(~set_valid), .found(free_hit), .idx(free_idx)
    );
    plru_oldest #(.WAYS(WAYS), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_old_a (
        .mask(mask_a), .rank(set_rank), .found(a_hit), .idx(a_idx)
    );
    plru_oldest #(.WAYS(WAYS), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_old_b (
        .mask(mask_b), .rank(set_rank), .found(b_hit), .idx(b_idx)
    );
    plru_oldest #(.WAYS(WAYS), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_old_all (
        .mask(set_valid), .rank(set_rank), .found(all_hit), .idx(all_idx)
    );

    // Excess is only consulted when both counts are above target.
    assign excess_a = {1'b0, held_a} - {1'b0, quota_a};
    assign excess_b = {1'b0, held_b} - {1'b0, quota_b};

    always_comb begin
        pol.any_free = free_hit;
        pol.over_a   = held_a > quota_a;
        pol.over_b   = held_b > quota_b;
        pol.owns_a   = a_hit;
        pol.owns_b   = b_hit;
        pol.b_ahead  = excess_b > excess_a;
        pick         = decide(pol);
        unique case (pick)
            PICK_FREE:   victim = free_idx;
            PICK_SHED_A: victim = a_idx;
            PICK_SHED_B: victim = b_idx;
            default:     victim = all_hit ? all_idx : '0;
        endcase
    end
endmodule

// File: rtl/part_lru_victim.sv
module part_lru_victim
    import plru_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int CNT_W  = 10,
    parameter int RANK_W = $clog2(WAYS),
    parameter int IDX_W  = $clog2(WAYS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   miss_valid,
    input  logic                   miss_pid,
    input  logic [WAYS-1:0]        set_valid,
    input  logic [WAYS-1:0]        set_owner,
    input  logic [WAYS*RANK_W-1:0] set_rank,
    input  logic [CNT_W-1:0]       quota_a,
    input  logic [CNT_W-1:0]       quota_b,
    output logic [IDX_W-1:0]       victim_way,
    output logic [CNT_W-1:0]       held_a,
    output logic [CNT_W-1:0]       held_b
);
    logic [NPROC-1:0][CNT_W-1:0] held;
    logic                        evict_live;
    logic                        evict_pid;

    assign held_a = held[PID_A];
    assign held_b = held[PID_B];

    plru_victim_sel #(
        .WAYS(WAYS), .CNT_W(CNT_W), .RANK_W(RANK_W), .IDX_W(IDX_W)
    ) u_sel (
        .set_valid(set_valid),
        .set_owner(set_owner),
        .set_rank (set_rank),
        .held_a   (held_a),
        .held_b   (held_b),
        .quota_a  (quota_a),
        .quota_b  (quota_b),
        .victim   (victim_way)
    );

    assign evict_live = miss_valid && set_valid[victim_way];
    assign evict_pid  = set_owner[victim_way];

    plru_occupancy #(.CNT_W(CNT_W)) u_occ (
        .clk     (clk),
        .rst     (rst),
        .fill    (miss_valid),
        .fill_pid(miss_pid),
        .drop    (evict_live),
        .drop_pid(evict_pid),
        .held    (held)
    );
endmodule

// File: rtl/part_lru_victim_chk.sv
module part_lru_victim_chk #(
    parameter int WAYS  = 8,
    parameter int CNT_W = 10,
    parameter int IDX_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             miss_valid,
    input logic             miss_pid,
    input logic [WAYS-1:0]  set_valid,
    input logic [WAYS-1:0]  set_owner,
    input logic [CNT_W-1:0] quota_a,
    input logic [CNT_W-1:0] quota_b,
    input logic [IDX_W-1:0] victim_way,
    input logic [CNT_W-1:0] held_a,
    input logic [CNT_W-1:0] held_b
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2: a free way always beats ownership rules
    a_r2_free_first: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !(&set_valid)) |-> !set_valid[victim_way]);

    // R3: only A over target and A present in the set
    a_r3_shed_a: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && (&set_valid) && (held_a > quota_a) && !(held_b > quota_b)
         && (|(set_valid & ~set_owner))) |-> !set_owner[victim_way]);

    // R4: only B over target and B present in the set
    a_r4_shed_b: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && (&set_valid) && (held_b > quota_b) && !(held_a > quota_a)
         && (|(set_valid & set_owner))) |-> set_owner[victim_way]);

    // R9: counts hold while no miss is presented
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> ($stable(held_a) && $stable(held_b)));

    // R9: a fill by A into a free way adds exactly one to A
    a_r9_fill_a: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !miss_pid && !set_valid[victim_way] && (held_a != CNT_MAX))
        |=> ((held_a - $past(held_a)) == CNT_W'(1)));

    // R10: a full count never wraps to zero
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (held_a == CNT_MAX && !(miss_valid && set_valid[victim_way] && !set_owner[victim_way]))
        |=> (held_a == CNT_MAX));
endmodule

bind part_lru_victim part_lru_victim_chk #(
    .WAYS(WAYS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .miss_valid(miss_valid),
    .miss_pid  (miss_pid),
    .set_valid (set_valid),
    .set_owner (set_owner),
    .quota_a   (quota_a),
    .quota_b   (quota_b),
    .victim_way(victim_way),
    .held_a    (held_a),
    .held_b    (held_b)
);

// File: tb/part_lru_victim_test.sv
module part_lru_victim_test;
    localparam int WAYS  = 4;
    localparam int CNT_W = 4;
    localparam int CMAX  = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       miss_valid = 1'b0;
    logic       miss_pid = 1'b0;
    logic [3:0] set_valid = '0;
    logic [3:0] set_owner = '0;
    logic [7:0] set_rank = '0;
    logic [3:0] quota_a;
    logic [3:0] quota_b;
    logic [1:0] victim_way;
    logic [3:0] held_a;
    logic [3:0] held_b;

    int  qa = 15;
    int  qb = 15;
    int  exp_a = 0;
    int  exp_b = 0;
    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    assign quota_a = 4'(qa);
    assign quota_b = 4'(qb);

    always #5 clk = ~clk;

    part_lru_victim #(.WAYS(WAYS), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_pid(miss_pid),
        .set_valid(set_valid), .set_owner(set_owner), .set_rank(set_rank),
        .quota_a(quota_a), .quota_b(quota_b), .victim_way(victim_way),
        .held_a(held_a), .held_b(held_b)
    );

    function automatic logic [7:0] rk(int w0, int w1, int w2, int w3);
        return {2'(w3), 2'(w2), 2'(w1), 2'(w0)};
    endfunction

    function automatic int oldest(logic [3:0] m, logic [7:0] r);
        int best = -1;
        int brk = -1;
        for (int i = 0; i < 4; i++) begin
            if (m[i] && int'(r[i*2 +: 2]) > brk) begin
                best = i;
                brk = int'(r[i*2 +: 2]);
            end
        end
        return best;
    endfunction

    function automatic int ref_victim(logic [3:0] v, logic [3:0] o, logic [7:0] r);
        int ia, ib;
        bit ca, cb;
        for (int i = 0; i < 4; i++)
            if (!v[i]) return i;
        ia = oldest(v & ~o, r);
        ib = oldest(v & o, r);
        ca = (exp_a > qa) && (ia >= 0);
        cb = (exp_b > qb) && (ib >= 0);
        if (ca && cb) return ((exp_b - qb) > (exp_a - qa)) ? ib : ia;
        if (ca) return ia;
        if (cb) return ib;
        return oldest(v, r);
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Present one set; optionally commit a fill and check the count update.
    task automatic apply(string req, string creq, bit commit, bit pid,
                         logic [3:0] v, logic [3:0] o, logic [7:0] r);
        int ev;
        @(negedge clk);
        set_valid = v; set_owner = o; set_rank = r;
        miss_pid = pid; miss_valid = commit;
        #1;
        ev = ref_victim(v, o, r);
        chk(req, int'(victim_way), ev);
        if (commit) begin
            if (!(v[ev] && o[ev] == pid)) begin
                if (v[ev]) begin
                    if (o[ev]) exp_b = (exp_b > 0) ? exp_b - 1 : 0;
                    else       exp_a = (exp_a > 0) ? exp_a - 1 : 0;
                end
                if (pid) exp_b = (exp_b < CMAX) ? exp_b + 1 : CMAX;
                else     exp_a = (exp_a < CMAX) ? exp_a + 1 : CMAX;
            end
            @(negedge clk);
            miss_valid = 1'b0;
            #1;
            chk({creq, " held_a"}, int'(held_a), exp_a);
            chk({creq, " held_b"}, int'(held_b), exp_b);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 held_a", int'(held_a), 0);
        chk("R1 held_b", int'(held_b), 0);
    endtask

    task automatic t_free_first();
        qa = 0; qb = 0;
        apply("R2 free way 2", "R9", 1, 0, 4'b1011, 4'b0000, rk(0, 1, 2, 3));
        apply("R2 all free", "R9", 1, 1, 4'b0000, 4'b1111, rk(3, 2, 1, 0));
    endtask

    task automatic t_shed_a();
        qa = 0; qb = 15;
        apply("R3 A over", "R9 evict A by B", 1, 1, 4'b1111, 4'b1010, rk(1, 3, 2, 0));
    endtask

    task automatic t_shed_b();
        qa = 15; qb = 1;
        apply("R4 B over", "R9 evict B by A", 1, 0, 4'b1111, 4'b1010, rk(3, 1, 0, 2));
    endtask

    task automatic t_at_quota();
        qa = exp_a; qb = exp_b;
        apply("R5 at target", "R9 same owner", 1, 0, 4'b1111, 4'b1010, rk(3, 1, 0, 2));
    endtask

    task automatic t_plain_lru();
        qa = 15; qb = 15;
        apply("R6 plain LRU", "R9", 1, 1, 4'b1111, 4'b1010, rk(0, 2, 3, 1));
    endtask

    task automatic t_none_owned();
        qa = 15; qb = 0;
        apply("R7 over but absent", "R9", 0, 0, 4'b1111, 4'b0000, rk(2, 0, 1, 3));
    endtask

    task automatic t_both_over();
        apply("R2 way 3 free", "R9", 1, 0, 4'b0111, 4'b1010, rk(0, 1, 2, 3));
        qa = 0; qb = 0;
        apply("R8 B larger excess", "R8", 0, 0, 4'b1111, 4'b1010, rk(3, 0, 2, 1));
        qb = 1;
        apply("R8 tie to A", "R8", 0, 0, 4'b1111, 4'b1010, rk(3, 0, 2, 1));
    endtask

    task automatic t_idle_hold();
        int a0, b0;
        @(negedge clk);
        miss_valid = 1'b0;
        a0 = int'(held_a); b0 = int'(held_b);
        repeat (4) @(negedge clk);
        #1;
        chk("R9 idle held_a", int'(held_a), a0);
        chk("R9 idle held_b", int'(held_b), b0);
    endtask

    task automatic t_saturate();
        qa = 15; qb = 15;
        for (int k = 0; k < 16; k++)
            apply("R2 fill", "R10 top", 1, 0, 4'b0000, 4'b0000, rk(0, 1, 2, 3));
        chk("R10 held_a at max", int'(held_a), CMAX);
        qb = 0;
        for (int k = 0; k < 3; k++)
            apply("R4 shed B", "R10 floor", 1, 0, 4'b1111, 4'b1111, rk(k, 3, 1, 0));
        chk("R10 held_b at zero", int'(held_b), 0);
    endtask

    initial begin
        t_reset();
        t_free_first();
        t_shed_a();
        t_shed_b();
        t_at_quota();
        t_plain_lru();
        t_none_owned();
        t_both_over();
        t_idle_hold();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule